// File: doc/BRIEF.md
# Serial-Programmed Eight-Channel Level Register Bank

This block is a three-wire serial slave that holds the setpoints of a multi-channel reference generator. An external controller pulls the active-low enable down and clocks 16-bit words in on the serial data pin. Each bit is taken on a rising serial clock edge, most significant bit first. When enable returns high, the block decodes the last word it captured. A well-formed word writes a 10-bit level into one of eight channel registers and also sets a stored clock-source select.

A buffered serial output repeats each input bit sixteen falling clock edges after it arrived. This lets several devices share enable and clock, with each output feeding the next device's input. All devices then commit together when enable rises.

The serial pins are asynchronous to the block clock. They are sampled through synchronizers, and their edges are detected in the block clock domain. For this reason the serial clock's high and low phases must each last several block clock cycles.

Top module: `serial_level_bank`

## Requirements
- R1: While enable is low, each rising serial clock edge shifts the serial data input into a 16-bit capture register, with the first bit received landing in bit 15.
- R2: On the rising edge of enable, a valid word writes bits 9..0 into the channel selected by bits 12..10, coded in binary (channel A = 0 … channel H = 7). Bit 13 is ignored.
- R3: While enable is high, serial clock edges change neither the capture register nor the serial output.
- R4: If fewer than 16 bits arrived in the enable-low period, the enable rise changes no channel register and not the clock select.
- R5: A captured word whose bit 15 is 1 changes no channel register and not the clock select.
- R6: If more than 16 bits arrive in one enable-low period, only the last 16 received are decoded.
- R7: The clock-select output follows bit 14 of each valid word (0 = internal, 1 = external) and is held otherwise.
- R8: The serial output, updated on falling serial clock edges, shows after falling edge number k+15 the bit taken on rising edge number k.
- R9: After reset, all channel outputs are zero, the clock-select output is 0 and the serial output is 0.
- R10: Writing one channel leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_en_n | input | 1 | Active-low frame enable, asynchronous |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Delayed serial output for chaining |
| osc_ext | output | 1 | Clock-source select, 1 = external |
| levels | output | NUM_CH*DATA_W | Channel registers, channel i at bits i*DATA_W upward |

## Verification
The assertions check on every cycle the following properties:
- the capture register moves only on a qualified clock rise and takes the input bit into bit 0;
- the serial output moves only on a qualified clock fall;
- the bit count saturates at 16;
- short or test-bit words leave every register untouched;
- a write lands in the addressed channel.

The directed scenarios are needed for the end-to-end behaviours:
- the 16-edge delay seen as a bit stream;
- last-16-bits decoding of an over-long frame;
- the don't-care address bit;
- the insensitivity to serial clock pulses while enable is high, shown through the stream that the next frame shifts out.

// File: rtl/crb_pkg.sv
// Package: frame layout shared by the serial level bank.
// Assumes a fixed 16-bit word; the field order is decoded by hardware.
package crb_pkg;
    localparam int FRAME_W = 16;
    localparam int LEVEL_W = 10;
    localparam int SEL_W   = 3;

    typedef struct packed {
        logic               test;    // must be 0 for a valid word
        logic               osc;     // 0 internal, 1 external
        logic               sel_dc;  // unused address bit
        logic [SEL_W-1:0]   sel;     // channel number
        logic [LEVEL_W-1:0] level;   // value to store
    } frame_t;
endpackage

// File: rtl/crb_edge_sync.sv
// Synchronizes one asynchronous pin into clk and flags its edges.
// Assumes STAGES >= 2 and pin phases longer than STAGES+1 clocks.
module crb_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Purpose: metastability chain plus one-cycle history for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            last_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~last_q;
    assign fall  = ~level & last_q;

    // R1: a detected rise is a one-cycle pulse.
    assert_rise_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/crb_shifter.sv
// Capture shift register with saturating bit count and a delayed
// serial output that is updated on qualified falling clock edges.
// Assumes shift and drive never occur in the same cycle.
module crb_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic               drive,
    input  logic               sdi,
    output logic [FRAME_W-1:0] word,
    output logic               full,
    output logic               sdo
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] word_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sdo_q;

    // Purpose: count received bits, restarting at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clear)                   cnt_q <= '0;
        else if (shift && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: shift the input bit in at the bottom, oldest bit at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (shift) word_q <= {word_q[FRAME_W-2:0], sdi};
    end

    // Purpose: present the top bit on the chain output at clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n)     sdo_q <= 1'b0;
        else if (drive) sdo_q <= word_q[FRAME_W-1];
    end

    assign word = word_q;
    assign full = (cnt_q == CNT_MAX);
    assign sdo  = sdo_q;

    assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(word_q));
    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> word_q[0] == $past(sdi));
    assert_sdo_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> $stable(sdo_q));
endmodule

// File: rtl/crb_bank.sv
// Bank of NUM_CH level registers with a single write port.
// Assumes at most one write per cycle; out-of-range channels are dropped.
module crb_bank #(
    parameter int NUM_CH  = 8,
    parameter int LEVEL_W = 10,
    parameter int SEL_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [LEVEL_W-1:0]        wr_level,
    output logic [NUM_CH*LEVEL_W-1:0] levels
);
    logic [LEVEL_W-1:0] level_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Purpose: load channel i when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                level_q[i] <= '0;
            else if (wr_en && wr_sel == SEL_W'(i))
                level_q[i] <= wr_level;
        end
        assign levels[i*LEVEL_W +: LEVEL_W] = level_q[i];
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_sel) < NUM_CH) |=>
            levels[int'($past(wr_sel))*LEVEL_W +: LEVEL_W] == $past(wr_level));
    assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(levels));
endmodule

// File: rtl/serial_level_bank.sv
// Three-wire serial slave that programs eight level registers and a
// clock-source select. The serial pins are sampled in the clk domain.
// Assumes the serial clock is low before enable falls.
module serial_level_bank #(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ser_clk,
    input  logic                                ser_en_n,
    input  logic                                ser_din,
    output logic                                ser_dout,
    output logic                                osc_ext,
    output logic [NUM_CH*crb_pkg::LEVEL_W-1:0]  levels
);
    import crb_pkg::*;

    logic sclk_lvl, sclk_rise, sclk_fall;
    logic en_lvl, en_rise, en_fall;
    logic din_lvl, din_rise_u, din_fall_u;
    logic [FRAME_W-1:0] word_bits;
    logic   full;
    frame_t frame;
    logic   commit;
    logic   osc_q;

    crb_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
        .clk(clk), .rst_n(rst_n), .pin(ser_clk),
        .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

    crb_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en (
        .clk(clk), .rst_n(rst_n), .pin(ser_en_n),
        .level(en_lvl), .rise(en_rise), .fall(en_fall));

    crb_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din (
        .clk(clk), .rst_n(rst_n), .pin(ser_din),
        .level(din_lvl), .rise(din_rise_u), .fall(din_fall_u));

    crb_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear(en_fall),
        .shift(sclk_rise & ~en_lvl),
        .drive(sclk_fall & ~en_lvl),
        .sdi(din_lvl),
        .word(word_bits), .full(full), .sdo(ser_dout));

    assign frame  = frame_t'(word_bits);
    assign commit = en_rise & full & ~frame.test;

    // Purpose: store the clock-source select from each valid word.
    always_ff @(posedge clk) begin
        if (!rst_n)      osc_q <= 1'b0;
        else if (commit) osc_q <= frame.osc;
    end
    assign osc_ext = osc_q;

    crb_bank #(.NUM_CH(NUM_CH), .LEVEL_W(LEVEL_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_sel(frame.sel), .wr_level(frame.level),
        .levels(levels));

    assert_short_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && !full) |=> ($stable(levels) && $stable(osc_q)));
    assert_test_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && frame.test) |=> ($stable(levels) && $stable(osc_q)));
    assert_osc_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> osc_q == $past(frame.osc));
endmodule

// File: tb/sim_serial_level_bank.sv
// Directed bench for serial_level_bank: one task per scenario.
module sim_serial_level_bank;
    localparam int NCH = 8;
    localparam int LW  = 10;
    localparam int H   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
    logic ser_dout, osc_ext;
    logic [NCH*LW-1:0] levels;

    int n_chk = 0, n_bad = 0;
    logic [LW-1:0] exp_lv [NCH];
    logic exp_osc = 1'b0;
    logic [63:0] seen;
    bit done = 0;

    always #2.5 clk = ~clk;

    serial_level_bank u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
        .ser_en_n(ser_en_n), .ser_din(ser_din), .ser_dout(ser_dout),
        .osc_ext(osc_ext), .levels(levels));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic t, input logic o, input logic dc,
                                       input logic [2:0] a, input logic [9:0] d);
        return {t, o, dc, a, d};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift n bits (MSB of the n-bit field first); records sdo after each fall.
    task automatic shift_bits(input logic [63:0] bits, input int n);
        ser_en_n = 1'b0;
        wait_n(H);
        for (int k = 0; k < n; k++) begin
            ser_din = bits[n-1-k];
            wait_n(H);
            ser_clk = 1'b1;
            wait_n(H);
            ser_clk = 1'b0;
            wait_n(H);
            seen[k] = ser_dout;
        end
        ser_en_n = 1'b1;
        wait_n(10);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++)
            chk(levels[i*LW +: LW] == exp_lv[i], req, 32'(levels[i*LW +: LW]), 32'(exp_lv[i]));
        chk(osc_ext == exp_osc, req, 32'(osc_ext), 32'(exp_osc));
    endtask

    task automatic t_reset;
        for (int i = 0; i < NCH; i++) exp_lv[i] = '0;
        exp_osc = 1'b0;
        check_all("R9 reset levels/osc");
        chk(ser_dout == 1'b0, "R9 reset sdo", 32'(ser_dout), 0);
    endtask

    // R1 R2 R10: each channel written in turn, bit 13 toggled as don't-care.
    task automatic t_all_channels;
        for (int i = 0; i < NCH; i++) begin
            logic [9:0] v = 10'(10'h2A5 ^ (i * 97));
            shift_bits({48'b0, mk(1'b0, 1'b0, 1'(i % 2), 3'(i), v)}, 16);
            exp_lv[i] = v;
            check_all("R2 R10 channel write");
        end
        shift_bits({48'b0, mk(1'b0, 1'b0, 1'b1, 3'd7, 10'h3FF)}, 16);
        exp_lv[7] = 10'h3FF;
        check_all("R1 R2 full-scale ch H");
    endtask

    task automatic t_osc;
        shift_bits({48'b0, mk(1'b0, 1'b1, 1'b0, 3'd3, 10'h111)}, 16);
        exp_lv[3] = 10'h111; exp_osc = 1'b1;
        check_all("R7 select external");
        shift_bits({48'b0, mk(1'b0, 1'b0, 1'b0, 3'd4, 10'h0F0)}, 16);
        exp_lv[4] = 10'h0F0; exp_osc = 1'b0;
        check_all("R7 select internal");
        shift_bits({48'b0, mk(1'b0, 1'b1, 1'b0, 3'd4, 10'h0F1)}, 16);
        exp_lv[4] = 10'h0F1; exp_osc = 1'b1;
        check_all("R7 select external again");
    endtask

    task automatic t_short;
        shift_bits({52'b0, 12'hABC}, 12);
        check_all("R4 short frame ignored");
        shift_bits({49'b0, 15'h0123}, 15);
        check_all("R4 15-bit frame ignored");
    endtask

    task automatic t_testbit;
        shift_bits({48'b0, mk(1'b1, 1'b0, 1'b0, 3'd0, 10'h155)}, 16);
        check_all("R5 test bit set ignored");
    endtask

    // R6 R8: 32 bits; last word decoded, sdo is input delayed by 16 edges.
    task automatic t_long;
        logic [15:0] wa = mk(1'b0, 1'b0, 1'b0, 3'd1, 10'h222);
        logic [15:0] wb = mk(1'b0, 1'b0, 1'b0, 3'd2, 10'h3C3);
        logic [63:0] b = {32'b0, wa, wb};
        shift_bits(b, 32);
        exp_lv[2] = 10'h3C3; exp_osc = 1'b0;
        check_all("R6 last 16 bits decoded");
        for (int f = 16; f <= 32; f++)
            chk(seen[f-1] == b[32-(f-15)], "R8 sdo delay", 32'(seen[f-1]), 32'(b[32-(f-15)]));
    endtask

    // R3: sclk pulses with enable high disturb nothing.
    task automatic t_ignore_high;
        logic [15:0] w1 = mk(1'b0, 1'b1, 1'b0, 3'd5, 10'h1E7);
        logic sdo0;
        shift_bits({48'b0, w1}, 16);
        exp_lv[5] = 10'h1E7; exp_osc = 1'b1;
        check_all("R3 setup frame");
        sdo0 = ser_dout;
        ser_din = 1'b1;
        for (int k = 0; k < 6; k++) begin
            wait_n(H); ser_clk = 1'b1; wait_n(H); ser_clk = 1'b0;
        end
        wait_n(H);
        chk(ser_dout == sdo0, "R3 sdo held while disabled", 32'(ser_dout), 32'(sdo0));
        check_all("R3 no update while disabled");
        shift_bits({48'b0, mk(1'b0, 1'b1, 1'b0, 3'd6, 10'h0AA)}, 16);
        exp_lv[6] = 10'h0AA;
        for (int f = 1; f <= 15; f++)
            chk(seen[f-1] == w1[15-f], "R3 capture untouched", 32'(seen[f-1]), 32'(w1[15-f]));
        check_all("R3 following frame");
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_all_channels();
        t_osc();
        t_short();
        t_testbit();
        t_long();
        t_ignore_high();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule